// File: doc/BRIEF.md
# Serial Audio Settings Receiver

This block is the write-only two-wire serial slave that sits in front of a stereo sound processor. A host addresses it, names a register slot, and then streams one or more data bytes. The block holds them in eight byte-wide slots. Bus lines are brought into the system clock domain and the bit timing is recovered from them. The block checks the device address and pulls the data line low in each acknowledge slot. It stores every accepted data byte and advances its slot pointer after each byte, so that a single burst can refresh the whole file.

The slots are not exposed as raw bytes. They are cut into the control fields that the analog chain consumes:

- an input-stage gain code and a zero-crossing mute mode flag;
- separate right and left output attenuation codes;
- bass and treble codes;
- a general mute flag;
- the input source code, together with a registered decode of that code.

A one-cycle strobe marks every write to the switch slot, and downstream logic uses it to restart its mute timeout. The bus clock must be at least eight times slower than the system clock. Reads and clock stretching are not supported.

Top module: `audio_ctl_rx`

## Requirements
- R1: Only the address byte 0x50 (7-bit address 0x28 with the direction bit 0) is acknowledged. Any other address byte, including 0x51, gets no acknowledge, and the rest of that transfer does not change any slot.
- R2: `sda_oe` is 1 throughout the ninth SCL high phase after each accepted address, subaddress and data byte. It is 0 at every other point where the bench samples it.
- R3: Only bits [2:0] of the subaddress byte select the slot. Bits [7:3] have no effect.
- R4: After each accepted data byte the slot pointer increments modulo 8. A burst of eight bytes fills every slot, and a burst starting at slot 6 continues into slots 7 and then 0. Slots 3 and 4 accept writes but drive no field.
- R5: Slot 0 drives `zc_mode` from bit 7 and `vol_code` from bits [5:0].
- R6: Slot 1 drives `att_right`[5:0] and slot 2 drives `att_left`[5:0]. Slot 5 drives `bass_code`[4:0] and slot 6 drives `treble_code`[4:0].
- R7: Slot 7 drives `gen_mute` from bit 7 and `src_sel` from bits [2:0]. `input_pick` decodes `src_sel` as follows: 111 gives 01 (stereo A), 110 gives 10 (stereo B), 0xx gives 00 (mono), and 10x gives 11 (unassigned).
- R8: Reset returns the receiver to idle and sets slot 7 to 0x80 and every other slot to 0x00. After reset, `gen_mute` is 1, `input_pick` is 00, and every other field is 0.
- R9: `switch_wr` pulses high for exactly one cycle for each data byte written to slot 7, whether or not the value changes.
- R10: A START condition inside a byte abandons that byte without writing it, and the receiver then expects a new address byte.
- R11: A STOP condition inside a byte ends the transfer without writing the partial byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge); 0 releases it |
| vol_code | output | 6 | Input-stage gain code (slot 0) |
| zc_mode | output | 1 | Zero-crossing mute mode (slot 0) |
| att_right | output | 6 | Right output attenuation (slot 1) |
| att_left | output | 6 | Left output attenuation (slot 2) |
| bass_code | output | 5 | Bass code (slot 5) |
| treble_code | output | 5 | Treble code (slot 6) |
| gen_mute | output | 1 | General mute (slot 7) |
| src_sel | output | 3 | Raw source code (slot 7) |
| input_pick | output | 2 | Decoded source choice |
| switch_wr | output | 1 | One-cycle strobe on each slot 7 write |

## Verification
The bench sweeps all 64 gain codes with both mode flag values, and all eight source codes. A wrong field slice or a wrong source decode therefore shows up as a mismatched output value. It sends bursts that wrap from slot 7 to slot 0, and a subaddress with high bits set. A pointer that saturates, or that decodes more than three bits, would leave the wrong slot written. It rewrites slot 7 with an unchanged value and counts strobes, which catches a strobe gated on a value change or stretched to two cycles. It also rejects foreign addresses and cuts bytes short with START and STOP. A receiver that stores partial bytes, or that keeps listening after an address mismatch, would corrupt fields the bench then reads back.

// File: rtl/acr_pkg.sv
package acr_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_ACK   = 2'd2,
    RX_SKIP  = 2'd3
  } rx_state_t;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_SUB  = 2'd1,
    PH_DATA = 2'd2
  } rx_phase_t;

  typedef enum logic [1:0] {
    PICK_MONO = 2'b00,
    PICK_A    = 2'b01,
    PICK_B    = 2'b10,
    PICK_NONE = 2'b11
  } pick_t;

  localparam int SLOT_GAIN   = 0;
  localparam int SLOT_RIGHT  = 1;
  localparam int SLOT_LEFT   = 2;
  localparam int SLOT_SPARE0 = 3;
  localparam int SLOT_SPARE1 = 4;
  localparam int SLOT_BASS   = 5;
  localparam int SLOT_TREBLE = 6;
  localparam int SLOT_SWITCH = 7;

  function automatic pick_t decode_pick(input logic [2:0] code);
    if (!code[2])           return PICK_MONO;
    else if (code[1:0] == 2'b11) return PICK_A;
    else if (code[1:0] == 2'b10) return PICK_B;
    else                    return PICK_NONE;
  endfunction

endpackage

// File: rtl/acr_line_sync.sv
module acr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_bit;
  logic scl_prev;
  logic sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_prev <= scl_bit;
      sda_prev <= sda_bit;
    end
  end

  assign scl_bit   = scl_pipe[STAGES-1];
  assign sda_bit   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_bit & ~scl_prev;
  assign scl_fall  = ~scl_bit & scl_prev;
  assign start_det = scl_bit & scl_prev & sda_prev & ~sda_bit;
  assign stop_det  = scl_bit & scl_prev & ~sda_prev & sda_bit;

endmodule

// File: rtl/acr_byte_rx.sv
module acr_byte_rx
  import acr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h28,
  parameter int         SUB_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_bit,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [SUB_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  localparam int          BYTE_BITS = 8;
  localparam int          CNT_W     = $clog2(BYTE_BITS + 1);
  localparam logic [7:0]  ADDR_BYTE = {DEV_ADDR, 1'b0};

  rx_state_t        state;
  rx_phase_t        phase;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shreg;
  logic [SUB_W-1:0] sub_ptr;
  logic             byte_done;

  assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      shreg   <= '0;
      sub_ptr <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= RX_SHIFT;
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state   <= RX_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          RX_SHIFT: begin
            if (scl_rise && bit_cnt != CNT_W'(BYTE_BITS)) begin
              shreg   <= {shreg[6:0], sda_bit};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              case (phase)
                PH_ADDR: begin
                  if (shreg == ADDR_BYTE) begin
                    state  <= RX_ACK;
                    sda_oe <= 1'b1;
                  end else begin
                    state <= RX_SKIP;
                  end
                end
                PH_SUB: begin
                  sub_ptr <= shreg[SUB_W-1:0];
                  state   <= RX_ACK;
                  sda_oe  <= 1'b1;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= sub_ptr;
                  wr_data <= shreg;
                  sub_ptr <= sub_ptr + 1'b1;
                  state   <= RX_ACK;
                  sda_oe  <= 1'b1;
                end
              endcase
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= RX_SHIFT;
              case (phase)
                PH_ADDR: phase <= PH_SUB;
                default: phase <= PH_DATA;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_ack_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));

  assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (sub_ptr == SUB_W'(wr_addr + 1'b1)));

  assert_start_aborts_R10: assert property (@(posedge clk) disable iff (rst)
    $past(start_det) |-> (!sda_oe && !wr_en));

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (rst)
    $past(stop_det) |-> (!sda_oe && !wr_en));

endmodule

// File: rtl/acr_regfile.sv
module acr_regfile
  import acr_pkg::*;
#(
  parameter int SUB_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SUB_W-1:0]          wr_addr,
  input  logic [7:0]                wr_data,
  output logic [(1<<SUB_W)-1:0][7:0] slots,
  output logic                      switch_wr
);
  localparam int NSLOTS = 1 << SUB_W;

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    localparam logic [7:0] RST_VAL = (i == SLOT_SWITCH) ? 8'h80 : 8'h00;
    always_ff @(posedge clk) begin
      if (rst)
        slots[i] <= RST_VAL;
      else if (wr_en && wr_addr == SUB_W'(i))
        slots[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) switch_wr <= 1'b0;
    else     switch_wr <= wr_en && (wr_addr == SUB_W'(SLOT_SWITCH));
  end

  assert_switch_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    switch_wr |-> ($past(wr_en) && $past(wr_addr) == SUB_W'(SLOT_SWITCH)));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    switch_wr |=> !switch_wr);

endmodule

// File: rtl/audio_ctl_rx.sv
module audio_ctl_rx
  import acr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h28,
  parameter int         SYNC_STAGES = 2,
  parameter int         SUB_W       = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic [5:0] vol_code,
  output logic       zc_mode,
  output logic [5:0] att_right,
  output logic [5:0] att_left,
  output logic [4:0] bass_code,
  output logic [4:0] treble_code,
  output logic       gen_mute,
  output logic [2:0] src_sel,
  output logic [1:0] input_pick,
  output logic       switch_wr
);
  localparam int NSLOTS = 1 << SUB_W;

  logic sda_bit, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [SUB_W-1:0] wr_addr;
  logic [7:0]       wr_data;
  logic [NSLOTS-1:0][7:0] slots;

  acr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  acr_byte_rx #(.DEV_ADDR(DEV_ADDR), .SUB_W(SUB_W)) u_rx (
    .clk(clk), .rst(rst), .sda_bit(sda_bit), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  acr_regfile #(.SUB_W(SUB_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slots(slots), .switch_wr(switch_wr)
  );

  assign zc_mode     = slots[SLOT_GAIN][7];
  assign vol_code    = slots[SLOT_GAIN][5:0];
  assign att_right   = slots[SLOT_RIGHT][5:0];
  assign att_left    = slots[SLOT_LEFT][5:0];
  assign bass_code   = slots[SLOT_BASS][4:0];
  assign treble_code = slots[SLOT_TREBLE][4:0];
  assign gen_mute    = slots[SLOT_SWITCH][7];
  assign src_sel     = slots[SLOT_SWITCH][2:0];

  always_ff @(posedge clk) begin
    if (rst) input_pick <= PICK_MONO;
    else     input_pick <= decode_pick(src_sel);
  end

  logic unused_bits;
  assign unused_bits = ^{slots[SLOT_SPARE0], slots[SLOT_SPARE1],
                         slots[SLOT_GAIN][6], slots[SLOT_RIGHT][7:6],
                         slots[SLOT_LEFT][7:6], slots[SLOT_BASS][7:5],
                         slots[SLOT_TREBLE][7:5], slots[SLOT_SWITCH][6:3]};

  assert_mute_after_reset_R8: assert property (@(posedge clk)
    $past(rst) |-> (gen_mute && input_pick == PICK_MONO));

  assert_pick_mono_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(src_sel[2]) |-> (input_pick == PICK_MONO));

  assert_pick_stereo_a_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(src_sel) == 3'b111) |-> (input_pick == PICK_A));

endmodule

// File: tb/audio_ctl_rx_test.sv
module audio_ctl_rx_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_scl = 1'b1;
  logic bus_sda = 1'b1;
  logic sda_oe;
  logic [5:0] vol_code, att_right, att_left;
  logic [4:0] bass_code, treble_code;
  logic zc_mode, gen_mute, switch_wr;
  logic [2:0] src_sel;
  logic [1:0] input_pick;

  int n_checks = 0;
  int n_fail = 0;
  int pulses = 0;
  int exp_pulses = 0;
  bit done = 0;
  logic [7:0] exp_slot [0:7];
  logic [7:0] tx_buf [0:15];

  always #4 clk = ~clk;

  audio_ctl_rx uut (
    .clk(clk), .rst(rst), .scl_in(bus_scl), .sda_in(bus_sda & ~sda_oe),
    .sda_oe(sda_oe), .vol_code(vol_code), .zc_mode(zc_mode),
    .att_right(att_right), .att_left(att_left), .bass_code(bass_code),
    .treble_code(treble_code), .gen_mute(gen_mute), .src_sel(src_sel),
    .input_pick(input_pick), .switch_wr(switch_wr)
  );

  always @(posedge clk) if (!rst && switch_wr) pulses++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    bus_sda = 1'b1; tick(Q); bus_scl = 1'b1; tick(Q);
    bus_sda = 1'b0; tick(Q); bus_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    bus_sda = 1'b0; tick(Q); bus_scl = 1'b1; tick(Q);
    bus_sda = 1'b1; tick(4 * Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      bus_sda = b[i]; tick(Q); bus_scl = 1'b1; tick(2 * Q);
      bus_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    bus_sda = 1'b1; tick(Q); bus_scl = 1'b1; tick(Q);
    acked = sda_oe; tick(Q);
    bus_scl = 1'b0; tick(Q);
  endtask

  function automatic logic [1:0] pick_of(input logic [2:0] c);
    if (!c[2]) return 2'b00;
    if (c[1:0] == 2'b11) return 2'b01;
    if (c[1:0] == 2'b10) return 2'b10;
    return 2'b11;
  endfunction

  // Full transfer; updates the model only when the address is ours
  task automatic xfer(input logic [7:0] adr, input logic [7:0] sub, input int n);
    bit a;
    bit ours;
    ours = (adr == 8'h50);
    bus_start();
    send_byte(adr, a);
    check(a == ours, "R1 address ack", a, ours);
    send_byte(sub, a);
    check(a == ours, "R2 subaddress ack", a, ours);
    for (int k = 0; k < n; k++) begin
      send_byte(tx_buf[k], a);
      check(a == ours, "R2 data ack", a, ours);
      if (ours) begin
        exp_slot[(sub[2:0] + k) % 8] = tx_buf[k];
        if ((sub[2:0] + k) % 8 == 7) exp_pulses++;
      end
    end
    bus_stop();
  endtask

  task automatic check_fields(input string tag);
    check(vol_code == exp_slot[0][5:0], {tag, " R5 vol_code"}, vol_code, exp_slot[0][5:0]);
    check(zc_mode == exp_slot[0][7], {tag, " R5 zc_mode"}, zc_mode, exp_slot[0][7]);
    check(att_right == exp_slot[1][5:0], {tag, " R6 att_right"}, att_right, exp_slot[1][5:0]);
    check(att_left == exp_slot[2][5:0], {tag, " R6 att_left"}, att_left, exp_slot[2][5:0]);
    check(bass_code == exp_slot[5][4:0], {tag, " R6 bass"}, bass_code, exp_slot[5][4:0]);
    check(treble_code == exp_slot[6][4:0], {tag, " R6 treble"}, treble_code, exp_slot[6][4:0]);
    check(gen_mute == exp_slot[7][7], {tag, " R7 gen_mute"}, gen_mute, exp_slot[7][7]);
    check(src_sel == exp_slot[7][2:0], {tag, " R7 src_sel"}, src_sel, exp_slot[7][2:0]);
    check(input_pick == pick_of(exp_slot[7][2:0]), {tag, " R7 input_pick"},
          input_pick, pick_of(exp_slot[7][2:0]));
    check(pulses == exp_pulses, {tag, " R9 strobe count"}, pulses, exp_pulses);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(5); rst = 1'b0; tick(2);
    for (int i = 0; i < 8; i++) exp_slot[i] = 8'h00;
    exp_slot[7] = 8'h80;
  endtask

  initial begin
    bit a;
    do_reset();
    check(sda_oe == 1'b0, "R8 idle release", sda_oe, 0);
    check_fields("R8 reset");

    // Full burst from slot 0
    for (int k = 0; k < 8; k++) tx_buf[k] = 8'hA0 + 8'(k * 7);
    tx_buf[7] = 8'h07;
    xfer(8'h50, 8'h00, 8);
    check_fields("R4 burst8");

    // Gain sweep with both mode flag values
    for (int v = 0; v < 64; v++) begin
      tx_buf[0] = {v[0], 1'b1, v[5:0]};
      xfer(8'h50, 8'h00, 1);
      check(vol_code == v[5:0], "R5 sweep vol_code", vol_code, v);
      check(zc_mode == v[0], "R5 sweep zc_mode", zc_mode, v[0]);
    end

    // Source code sweep with alternating mute
    for (int s = 0; s < 8; s++) begin
      tx_buf[0] = {s[0], 4'b0101, s[2:0]};
      xfer(8'h50, 8'h07, 1);
      check_fields("R7 src sweep");
    end

    // Same value rewritten still strobes
    tx_buf[0] = exp_slot[7];
    xfer(8'h50, 8'h07, 1);
    check_fields("R9 same value");

    // High subaddress bits ignored
    tx_buf[0] = 8'h1B;
    xfer(8'h50, 8'hFD, 1);
    check(bass_code == 5'h1B, "R3 high sub bits", bass_code, 27);
    check_fields("R3");

    // Wrap from slot 6 through 7 to 0
    tx_buf[0] = 8'h0C; tx_buf[1] = 8'h86; tx_buf[2] = 8'h15;
    xfer(8'h50, 8'h06, 3);
    check(vol_code == 6'h15, "R4 wrap to slot0", vol_code, 21);
    check_fields("R4 wrap");

    // Foreign addresses
    tx_buf[0] = 8'h3F; tx_buf[1] = 8'h3F;
    xfer(8'h52, 8'h01, 2);
    check_fields("R1 foreign");
    xfer(8'h51, 8'h01, 2);
    check_fields("R1 read bit");

    // START in mid-byte: slot 1 write abandoned, new transfer to slot 2
    bus_start();
    send_byte(8'h50, a);
    send_byte(8'h01, a);
    send_bits(8'h2A, 3);
    tx_buf[0] = 8'h33;
    xfer(8'h50, 8'h02, 1);
    check(att_left == 6'h33, "R10 restart write", att_left, 51);
    check(att_right == exp_slot[1][5:0], "R10 aborted byte", att_right, exp_slot[1][5:0]);
    check_fields("R10");

    // STOP in mid-byte
    bus_start();
    send_byte(8'h50, a);
    send_byte(8'h05, a);
    send_bits(8'h0F, 4);
    bus_stop();
    check(bass_code == exp_slot[5][4:0], "R11 partial byte", bass_code, exp_slot[5][4:0]);
    check(sda_oe == 1'b0, "R11 released", sda_oe, 0);

    // Reset after traffic restores mute
    tx_buf[0] = 8'h07;
    xfer(8'h50, 8'h07, 1);
    do_reset();
    pulses = 0; exp_pulses = 0;
    check(gen_mute == 1'b1, "R8 mute after reset", gen_mute, 1);
    check_fields("R8 second reset");

    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule